// File: doc/BRIEF.md
# Gaussian Parameter Run-Length Codec

This block shrinks the traffic of per-pixel background-model parameters between a segmentation pipeline and its frame store. Every pixel carries a fixed set of ranked Gaussians, each with a three-component colour mean, one deviation and a weight. The encoder takes these sets in scan order. When every rank of a pixel resembles the same rank of the pixel just before it, the pixel is folded into the current run and is not written again. The stored word is the first pixel of the run plus a count of the pixels that follow it.

Two Gaussians resemble each other when the axis-aligned cubes they span in colour space overlap enough. Each cube is centred on the mean and extends by the deviation on every side. The shared volume is compared with a programmable fraction of the smaller cube's volume. The decoder reverses the process and replays each stored set once for itself and once for every pixel in its count, so the next frame again sees exactly one set per pixel. Both sides use valid/ready streams.

The encoder has three states. EMPTY means no run is held, and it moves to RUN or SEAL on the first pixel. RUN means a run is open: it stays in RUN on an extension or a split, and goes to SEAL on a closing pixel. SEAL means the run is closed and waits for the output slot, then returns to EMPTY. The decoder has two states. IDLE accepts a word and moves to PLAY. PLAY replays the word and returns to IDLE after the last copy has been taken.

Top module: `gmix_run_codec`

## Requirements
- R1: After reset, enc_valid and out_valid are 0, and pix_ready and rd_ready are 1.
- R2: A pixel word packs NG ranks, with rank g at bits [g*GW +: GW] and GW = 3*MW+SW+WW. Inside a rank, mean component k sits at [k*MW +: MW], the deviation at [3*MW +: SW] and the weight above it. Cube side per axis is the closed integer interval mean±dev. Two ranks are similar when 16 × (product of per-axis intersection lengths) ≥ sim_thr × (2·min(dev)+1)³. A pixel is equivalent to its predecessor when every rank is similar.
- R3: An accepted pixel that is equivalent to the pixel accepted just before it, inside an open run, adds one to the count. An encoded word carries the first pixel of its run and the number of pixels that follow it.
- R4: A non-equivalent pixel ends the open run, which is emitted, and starts a new run of its own.
- R5: The count is CNW bits wide. A run whose count is at its maximum (255) is emitted when the next pixel arrives, and that pixel starts a new run even when it is equivalent.
- R6: A pixel marked pix_eol is the last pixel of its run. The run is emitted, and the next pixel always starts a new run.
- R7: A pixel marked pix_eof also ends its run, and the emitted word has enc_eof set. The decoder raises out_eof on the final replayed copy of a word that has rd_eof set.
- R8: The decoder outputs each accepted word count+1 times, one copy per cycle with out_ready high, and then drops out_valid.
- R9: While a valid output is held with its ready low, its data and flags stay unchanged. No word and no pixel is lost or duplicated under any ready pattern.
- R10: sim_thr is applied as given. With 0, every pixel is equivalent. With a value above 16, even identical pixels start new runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sim_thr | input | TF+1 | Similarity fraction in sixteenths |
| pix_valid | input | 1 | Pixel set offered to the encoder |
| pix_ready | output | 1 | Encoder accepts the pixel |
| pix_data | input | NG*GW | Ranked Gaussian set of one pixel |
| pix_eol | input | 1 | Pixel is the last of its line |
| pix_eof | input | 1 | Pixel is the last of its frame |
| enc_valid | output | 1 | Encoded word available |
| enc_ready | input | 1 | Sink takes the encoded word |
| enc_data | output | NG*GW | First pixel set of the run |
| enc_count | output | CNW | Pixels following the first one |
| enc_eof | output | 1 | Run ended the frame |
| rd_valid | input | 1 | Stored word offered to the decoder |
| rd_ready | output | 1 | Decoder accepts the word |
| rd_data | input | NG*GW | Stored pixel set |
| rd_count | input | CNW | Stored repeat count |
| rd_eof | input | 1 | Stored frame-end flag |
| out_valid | output | 1 | Decoded pixel set available |
| out_ready | input | 1 | Consumer takes the pixel set |
| out_data | output | NG*GW | Decoded pixel set |
| out_eof | output | 1 | Last pixel of the frame |

## Verification
The bench builds the codec with its defaults: two ranks, 8-bit means, 6-bit deviations, 4 fractional threshold bits and an 8-bit count. With these values a 300-pixel stretch of identical sets crosses the 256-pixel saturation point. A mean shift of 3 against a deviation of 4 places the similarity boundary exactly between thresholds 10 and 11. A chain of small shifts shows that the comparison is made with the predecessor and not with the run head. Every scenario is pushed through both halves, once with ready always high and once with a stalling ready pattern.

// File: rtl/grc_pkg.sv
package grc_pkg;
    typedef enum logic [1:0] {ENC_EMPTY, ENC_RUN, ENC_SEAL} enc_state_e;
    typedef enum logic {DEC_IDLE, DEC_PLAY} dec_state_e;
endpackage

// File: rtl/grc_cube_sim.sv
module grc_cube_sim #(
    parameter int MW = 8,
    parameter int SW = 6,
    parameter int TF = 4
) (
    input  logic [3*MW-1:0] a_mean,
    input  logic [SW-1:0]   a_sd,
    input  logic [3*MW-1:0] b_mean,
    input  logic [SW-1:0]   b_sd,
    input  logic [TF:0]     thr,
    output logic            similar
);
    localparam int PW = MW + 2;
    localparam int LW = SW + 1;
    localparam int VW = 3 * LW;
    localparam int CW = VW + TF + 1;
    localparam logic [PW-1:0] OFS = PW'(2 ** SW);

    logic [LW-1:0] len [3];
    logic [SW-1:0] smin;
    logic [LW-1:0] side;
    logic [VW-1:0] ovl, minv;

    for (genvar k = 0; k < 3; k++) begin : g_axis
        logic [PW-1:0] alo, ahi, blo, bhi, lo, hi;
        assign alo = PW'(a_mean[k*MW +: MW]) + OFS - PW'(a_sd);
        assign ahi = PW'(a_mean[k*MW +: MW]) + OFS + PW'(a_sd);
        assign blo = PW'(b_mean[k*MW +: MW]) + OFS - PW'(b_sd);
        assign bhi = PW'(b_mean[k*MW +: MW]) + OFS + PW'(b_sd);
        assign lo  = (alo > blo) ? alo : blo;
        assign hi  = (ahi < bhi) ? ahi : bhi;
        assign len[k] = (hi >= lo) ? (LW'(hi - lo) + LW'(1)) : '0;
    end

    assign smin = (a_sd < b_sd) ? a_sd : b_sd;
    assign side = {smin, 1'b1};
    assign ovl  = VW'(len[0]) * VW'(len[1]) * VW'(len[2]);
    assign minv = VW'(side) * VW'(side) * VW'(side);
    assign similar = CW'({ovl, {TF{1'b0}}}) >= (CW'(thr) * CW'(minv));
endmodule

// File: rtl/grc_encoder.sv
module grc_encoder
    import grc_pkg::*;
#(
    parameter int NG  = 2,
    parameter int MW  = 8,
    parameter int SW  = 6,
    parameter int WW  = 8,
    parameter int TF  = 4,
    parameter int CNW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TF:0]            thr,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [NG*(3*MW+SW+WW)-1:0] in_data,
    input  logic                   in_eol,
    input  logic                   in_eof,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [NG*(3*MW+SW+WW)-1:0] out_data,
    output logic [CNW-1:0]         out_cnt,
    output logic                   out_eof
);
    localparam int GW = 3*MW + SW + WW;
    localparam int EW = NG * GW;
    localparam int MS = 3*MW + SW;
    localparam logic [CNW-1:0] CMAX = {CNW{1'b1}};

    enc_state_e     state, nxt;
    logic [EW-1:0]  head;
    logic [MS-1:0]  prev_ms [NG];
    logic [CNW-1:0] cnt;
    logic           heof;
    logic [NG-1:0]  sim_vec;
    logic           equiv, slot_free, acc, close_in, extend, split, seal_emit, emit;

    for (genvar g = 0; g < NG; g++) begin : g_rank
        grc_cube_sim #(.MW(MW), .SW(SW), .TF(TF)) u_sim (
            .a_mean (prev_ms[g][3*MW-1:0]),
            .a_sd   (prev_ms[g][3*MW +: SW]),
            .b_mean (in_data[g*GW +: 3*MW]),
            .b_sd   (in_data[g*GW + 3*MW +: SW]),
            .thr    (thr),
            .similar(sim_vec[g])
        );
    end

    assign equiv     = &sim_vec;
    assign slot_free = !out_valid || out_ready;
    assign in_ready  = (state != ENC_SEAL) && slot_free;
    assign acc       = in_valid && in_ready;
    assign close_in  = in_eol || in_eof;
    assign extend    = (state == ENC_RUN) && equiv && (cnt != CMAX);
    assign split     = acc && (state == ENC_RUN) && !extend;
    assign seal_emit = (state == ENC_SEAL) && slot_free;
    assign emit      = split || seal_emit;

    always_comb begin
        nxt = state;
        unique case (state)
            ENC_EMPTY: if (acc) nxt = close_in ? ENC_SEAL : ENC_RUN;
            ENC_RUN:   if (acc) nxt = close_in ? ENC_SEAL : ENC_RUN;
            ENC_SEAL:  if (slot_free) nxt = ENC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENC_EMPTY;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head      <= '0;
            cnt       <= '0;
            heof      <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_cnt   <= '0;
            out_eof   <= 1'b0;
            for (int g = 0; g < NG; g++) prev_ms[g] <= '0;
        end else begin
            if (emit) begin
                out_valid <= 1'b1;
                out_data  <= head;
                out_cnt   <= cnt;
                out_eof   <= heof;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            if (acc) begin
                for (int g = 0; g < NG; g++) prev_ms[g] <= in_data[g*GW +: MS];
                heof <= in_eof;
                if (extend) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    head <= in_data;
                    cnt  <= '0;
                end
            end
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_cnt) && $stable(out_eof));
    assert_seal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && close_in |=> !in_ready);
    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (state == ENC_RUN) && (cnt == CMAX) |=> out_valid && (out_cnt == CMAX));
endmodule

// File: rtl/grc_decoder.sv
module grc_decoder
    import grc_pkg::*;
#(
    parameter int EW  = 76,
    parameter int CNW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [EW-1:0]  in_data,
    input  logic [CNW-1:0] in_cnt,
    input  logic           in_eof,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [EW-1:0]  out_data,
    output logic           out_eof
);
    dec_state_e     state, nxt;
    logic [EW-1:0]  ent;
    logic [CNW-1:0] rem;
    logic           feof;

    assign in_ready  = (state == DEC_IDLE);
    assign out_valid = (state == DEC_PLAY);
    assign out_data  = ent;
    assign out_eof   = feof && (rem == '0);

    always_comb begin
        nxt = state;
        unique case (state)
            DEC_IDLE: if (in_valid) nxt = DEC_PLAY;
            DEC_PLAY: if (out_ready && rem == '0) nxt = DEC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DEC_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent  <= '0;
            rem  <= '0;
            feof <= 1'b0;
        end else if (in_valid && in_ready) begin
            ent  <= in_data;
            rem  <= in_cnt;
            feof <= in_eof;
        end else if (out_valid && out_ready && rem != '0) begin
            rem <= rem - 1'b1;
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eof));
    assert_play_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && !in_ready);
endmodule

// File: rtl/gmix_run_codec.sv
module gmix_run_codec #(
    parameter int NG  = 2,
    parameter int MW  = 8,
    parameter int SW  = 6,
    parameter int WW  = 8,
    parameter int TF  = 4,
    parameter int CNW = 8,
    localparam int EW = NG * (3*MW + SW + WW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TF:0]    sim_thr,
    input  logic           pix_valid,
    output logic           pix_ready,
    input  logic [EW-1:0]  pix_data,
    input  logic           pix_eol,
    input  logic           pix_eof,
    output logic           enc_valid,
    input  logic           enc_ready,
    output logic [EW-1:0]  enc_data,
    output logic [CNW-1:0] enc_count,
    output logic           enc_eof,
    input  logic           rd_valid,
    output logic           rd_ready,
    input  logic [EW-1:0]  rd_data,
    input  logic [CNW-1:0] rd_count,
    input  logic           rd_eof,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [EW-1:0]  out_data,
    output logic           out_eof
);
    grc_encoder #(.NG(NG), .MW(MW), .SW(SW), .WW(WW), .TF(TF), .CNW(CNW)) u_enc (
        .clk(clk), .rst_n(rst_n), .thr(sim_thr),
        .in_valid(pix_valid), .in_ready(pix_ready), .in_data(pix_data),
        .in_eol(pix_eol), .in_eof(pix_eof),
        .out_valid(enc_valid), .out_ready(enc_ready), .out_data(enc_data),
        .out_cnt(enc_count), .out_eof(enc_eof)
    );

    grc_decoder #(.EW(EW), .CNW(CNW)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rd_valid), .in_ready(rd_ready), .in_data(rd_data),
        .in_cnt(rd_count), .in_eof(rd_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_eof(out_eof)
    );
endmodule

// File: tb/tb_gmix_run_codec.sv
`timescale 1ns/1ps
module tb_gmix_run_codec;
    localparam int NG = 2, MW = 8, SW = 6, WW = 8, TF = 4, CNW = 8;
    localparam int GW = 3*MW + SW + WW;
    localparam int EW = NG * GW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [TF:0] sim_thr = '0;
    logic pix_valid = 0, pix_eol = 0, pix_eof = 0, enc_ready = 1;
    logic [EW-1:0] pix_data = '0, rd_data = '0;
    logic rd_valid = 0, rd_eof = 0, out_ready = 1;
    logic [CNW-1:0] rd_count = '0;
    logic pix_ready, enc_valid, enc_eof, rd_ready, out_valid, out_eof;
    logic [EW-1:0] enc_data, out_data;
    logic [CNW-1:0] enc_count;

    gmix_run_codec #(.NG(NG), .MW(MW), .SW(SW), .WW(WW), .TF(TF), .CNW(CNW)) dut (.*);

    always #4 clk = ~clk;

    int nchk = 0, nfail = 0;
    logic [EW-1:0] px [0:511];
    bit peol [0:511], peof [0:511];
    logic [EW-1:0] ew_data [0:511];
    int ew_cnt [0:511];
    bit ew_eof [0:511];
    int nexp;

    task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [GW-1:0] gs(int y, int cb, int cr, int sd, int w);
        return {WW'(w), SW'(sd), MW'(cr), MW'(cb), MW'(y)};
    endfunction

    function automatic bit sim_g(logic [GW-1:0] a, logic [GW-1:0] b, int thr);
        int sa, sb, ovl, lo, hi, ma, mb, sm;
        sa = int'(a[3*MW +: SW]);
        sb = int'(b[3*MW +: SW]);
        ovl = 1;
        for (int k = 0; k < 3; k++) begin
            ma = int'(a[k*MW +: MW]);
            mb = int'(b[k*MW +: MW]);
            lo = (ma - sa > mb - sb) ? ma - sa : mb - sb;
            hi = (ma + sa < mb + sb) ? ma + sa : mb + sb;
            ovl = ovl * ((hi >= lo) ? hi - lo + 1 : 0);
        end
        sm = 2 * ((sa < sb) ? sa : sb) + 1;
        return ovl * 16 >= thr * sm * sm * sm;
    endfunction

    function automatic bit equiv(logic [EW-1:0] a, logic [EW-1:0] b, int thr);
        bit r = 1;
        for (int g = 0; g < NG; g++) r &= sim_g(a[g*GW +: GW], b[g*GW +: GW], thr);
        return r;
    endfunction

    task automatic build_expected(int n, int thr);
        int head = 0, cnt = 0;
        bit open = 0;
        nexp = 0;
        for (int i = 0; i < n; i++) begin
            if (!open) begin
                head = i; cnt = 0; open = 1;
            end else if (equiv(px[i-1], px[i], thr) && cnt < 255) begin
                cnt++;
            end else begin
                ew_data[nexp] = px[head]; ew_cnt[nexp] = cnt; ew_eof[nexp] = 0; nexp++;
                head = i; cnt = 0;
            end
            if (peol[i] || peof[i]) begin
                ew_data[nexp] = px[head]; ew_cnt[nexp] = cnt; ew_eof[nexp] = peof[i]; nexp++;
                open = 0;
            end
        end
    endtask

    task automatic run_enc(int n, int thr, bit stall, string tag);
        int idx = 0, ng = 0, cyc = 0;
        bit pf, held = 0;
        logic [EW-1:0] hd;
        logic [CNW-1:0] hc;
        sim_thr = TF'(0) + (TF+1)'(thr);
        build_expected(n, thr);
        while ((idx < n || ng < nexp) && cyc < 20000) begin
            @(negedge clk);
            pix_valid = (idx < n);
            pix_data  = (idx < n) ? px[idx] : '0;
            pix_eol   = (idx < n) ? peol[idx] : 1'b0;
            pix_eof   = (idx < n) ? peof[idx] : 1'b0;
            enc_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            #1;
            if (held) chk(enc_valid && enc_data == hd && enc_count == hc, "R9", "enc stall hold",
                          {enc_valid, enc_count}, {1'b1, hc});
            if (enc_valid && enc_ready) begin
                if (ng < nexp) begin
                    chk(enc_data == ew_data[ng] && enc_count == CNW'(ew_cnt[ng]), tag, "enc word",
                        {enc_data, enc_count}, {ew_data[ng], CNW'(ew_cnt[ng])});
                    chk(enc_eof == ew_eof[ng], "R7", "enc eof", enc_eof, ew_eof[ng]);
                end else chk(0, tag, "extra enc word", enc_count, 0);
                ng++;
            end
            held = enc_valid && !enc_ready;
            hd = enc_data; hc = enc_count;
            pf = pix_valid && pix_ready;
            @(posedge clk);
            if (pf) idx++;
            cyc++;
        end
        @(negedge clk);
        pix_valid = 0; pix_eol = 0; pix_eof = 0; enc_ready = 1;
        #1;
        chk(ng == nexp && idx == n, tag, "enc word count", ng, nexp);
        chk(!enc_valid, tag, "enc idle after stream", enc_valid, 0);
    endtask

    task automatic run_dec(int n, bit stall);
        int wi = 0, op = 0, cyc = 0, k = 0;
        bit rf, held = 0;
        logic [EW-1:0] ed [0:511];
        bit ee [0:511];
        logic [EW-1:0] hd;
        for (int w = 0; w < nexp; w++)
            for (int c = 0; c <= ew_cnt[w]; c++) begin
                ed[k] = ew_data[w]; ee[k] = ew_eof[w] && (c == ew_cnt[w]); k++;
            end
        chk(k == n, "R8", "expanded length", k, n);
        while ((wi < nexp || op < k) && cyc < 20000) begin
            @(negedge clk);
            rd_valid = (wi < nexp);
            rd_data  = (wi < nexp) ? ew_data[wi] : '0;
            rd_count = (wi < nexp) ? CNW'(ew_cnt[wi]) : '0;
            rd_eof   = (wi < nexp) ? ew_eof[wi] : 1'b0;
            out_ready = stall ? ((cyc % 4) != 2) : 1'b1;
            #1;
            if (held) chk(out_valid && out_data == hd, "R9", "dec stall hold", out_data, hd);
            if (out_valid && out_ready) begin
                if (op < k) begin
                    chk(out_data == ed[op], "R8", "dec pixel", out_data, ed[op]);
                    chk(out_eof == ee[op], "R7", "dec eof", out_eof, ee[op]);
                end else chk(0, "R8", "extra dec pixel", out_data, 0);
                op++;
            end
            held = out_valid && !out_ready;
            hd = out_data;
            rf = rd_valid && rd_ready;
            @(posedge clk);
            if (rf) wi++;
            cyc++;
        end
        @(negedge clk);
        rd_valid = 0; out_ready = 1;
        #1;
        chk(op == k, "R8", "dec pixel count", op, k);
        chk(!out_valid, "R8", "dec idle after stream", out_valid, 0);
    endtask

    task automatic clear_marks(int n);
        for (int i = 0; i < n; i++) begin peol[i] = 0; peof[i] = 0; end
    endtask

    task automatic both(int n, int thr, bit stall, string tag);
        run_enc(n, thr, stall, tag);
        run_dec(n, stall);
    endtask

    task automatic t_reset();
        #1;
        chk(!enc_valid && !out_valid, "R1", "valids after reset", {enc_valid, out_valid}, 0);
        chk(pix_ready && rd_ready, "R1", "readies after reset", {pix_ready, rd_ready}, 2'b11);
    endtask

    task automatic t_basic(bit stall);
        clear_marks(6);
        px[0] = {gs(40,60,80,5,20), gs(100,120,130,4,50)};
        px[1] = {gs(40,60,80,5,20), gs(101,120,130,4,50)};
        px[2] = {gs(40,60,80,5,20), gs(102,120,130,4,51)};
        px[3] = {gs(40,60,80,5,20), gs(200,120,130,4,50)};
        px[4] = px[3];
        px[5] = px[3]; peof[5] = 1;
        both(6, 10, stall, "R3");
        chk(nexp == 2, "R4", "basic run split", nexp, 2);
    endtask

    task automatic t_thresh();
        clear_marks(3);
        px[0] = {gs(10,10,10,4,9), gs(50,50,50,4,9)};
        px[1] = {gs(10,10,10,4,9), gs(53,50,50,4,9)};
        px[2] = px[1]; peof[2] = 1;
        both(3, 10, 0, "R2");
        chk(nexp == 1, "R2", "boundary thr10 merges", nexp, 1);
        both(3, 11, 0, "R2");
        chk(nexp == 2, "R2", "boundary thr11 splits", nexp, 2);
        px[1] = {gs(10,10,10,4,9), gs(200,50,50,4,9)};
        px[2] = px[0];
        both(3, 0, 0, "R10");
        chk(nexp == 1, "R10", "thr0 merges disjoint", nexp, 1);
        px[1] = px[0];
        both(3, 17, 0, "R10");
        chk(nexp == 3, "R10", "thr17 splits identical", nexp, 3);
    endtask

    task automatic t_rank();
        clear_marks(3);
        px[0] = {gs(10,10,10,3,9), gs(50,50,50,4,9)};
        px[1] = {gs(90,10,10,3,9), gs(50,50,50,4,9)};
        px[2] = px[1]; peof[2] = 1;
        both(3, 8, 0, "R2");
        chk(nexp == 2, "R2", "rank1 difference splits", nexp, 2);
    endtask

    task automatic t_sat(bit stall);
        clear_marks(300);
        for (int i = 0; i < 300; i++) px[i] = {gs(7,8,9,2,1), gs(70,80,90,3,5)};
        peof[299] = 1;
        both(300, 8, stall, "R5");
        chk(nexp == 2 && ew_cnt[0] == 255 && ew_cnt[1] == 43, "R5", "saturated counts",
            {32'(ew_cnt[0]), 32'(ew_cnt[1])}, {32'd255, 32'd43});
    endtask

    task automatic t_line();
        clear_marks(8);
        for (int i = 0; i < 8; i++) px[i] = {gs(7,8,9,2,1), gs(70,80,90,3,5)};
        peol[2] = 1;
        px[4] = {gs(7,8,9,2,1), gs(170,80,90,3,5)}; peol[4] = 1;
        px[5] = px[4]; px[6] = px[4]; px[7] = px[4]; peof[7] = 1;
        both(8, 8, 1, "R6");
        chk(nexp == 4, "R6", "line ends close runs", nexp, 4);
    endtask

    task automatic t_chain();
        clear_marks(8);
        for (int i = 0; i < 8; i++) px[i] = {gs(20,20,20,4,3), gs(20 + 3*i,60,60,4,3)};
        peof[7] = 1;
        both(8, 10, 0, "R3");
        chk(nexp == 1 && ew_cnt[0] == 7, "R3", "drift chain one run", ew_cnt[0], 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic(0);
        t_basic(1);
        t_thresh();
        t_rank();
        t_sat(0);
        t_sat(1);
        t_line();
        t_chain();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule